// File: doc/BRIEF.md
# Link Rate Reconfiguration Handshake

This block lets a serial link transmitter move between three line rates while the link is running. Every rate is produced from one shared 135 MHz reference clock. Only the transmit PLL divide ratio changes, so the block outputs the divider value for the rate in use. A rate request from inside the transmitter is latched. The block then raises a reconfiguration request towards user logic, which drives the transceiver reconfiguration controller.

The exchange has three phases, and user logic owns the second and third. The block raises its request and waits for an acknowledge. It then waits for the busy input to rise and fall again. The falling edge of busy completes the change, and the new rate becomes the current rate. Transmit data is flagged invalid for the whole exchange. A programmable watchdog abandons an exchange whose acknowledge or busy phase stalls. In that case the old rate stays in force. A request that arrives during an exchange waits in a one-entry slot and is served once the exchange is finished.

Top module: `rate_reconfig_hs`

## Requirements
- R1: After a synchronous reset, with `rst_n` low at a clock edge, the outputs are: `cur_rate` equal to the DEFAULT_RATE parameter (default code 0), `reconfig_req` low, `change_done` low, `timeout_err` low, `tx_data_valid` high, and `pll_div` set to the default rate's divider.
- R2: Rate codes map to dividers as follows: code 0 (1.62 Gb/s) gives 12, code 1 (2.7 Gb/s) gives 20 and code 2 (5.4 Gb/s) gives 40. `pll_div` always shows the divider of the code on `reconfig_rate`.
- R3: A legal request, with `rate_req_valid` high and `rate_req_code` from 0 to 2, sampled while the block is idle raises `reconfig_req` after the second clock edge that follows. `reconfig_rate` then carries the requested code.
- R4: `reconfig_req` stays high until `reconfig_ack` is sampled high. It is low in the cycle after that edge.
- R5: After the acknowledge, the block waits for `reconfig_busy` to go high and then low. `change_done` is high for exactly one cycle, the cycle after the edge at which busy is first sampled low. `change_done` never rises while busy is high.
- R6: `cur_rate` changes only at the edge that ends the `change_done` cycle. It takes the requested code at that edge.
- R7: `tx_data_valid` is low from the first cycle of `reconfig_req` up to and including the `change_done` cycle. It is high whenever the block is idle.
- R8: A legal request arriving during an exchange is held and does not alter `reconfig_rate` for the exchange in progress. It starts its own exchange right after the current one ends, with no further input. If several requests arrive, the newest one is held.
- R9: A request with code 3 is ignored. No exchange starts, `cur_rate` does not change, and any request already held is kept.
- R10: If `timeout_limit` is non-zero and the block spends `timeout_limit` cycles in one waiting phase (acknowledge, busy rise or busy fall) without progress, it returns to idle. `timeout_err` is then high for one cycle, `reconfig_req` is low and `cur_rate` is unchanged.
- R11: A `timeout_limit` of zero disables the timeout, and the block waits without limit.
- R12: An acknowledge sampled at the same edge at which the timeout would expire counts as progress. No timeout is flagged and the exchange continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_req_valid | input | 1 | Rate change request strobe from the transmitter |
| rate_req_code | input | 2 | Requested rate code (0, 1, 2; 3 is illegal) |
| timeout_limit | input | TMO_W | Cycles allowed per waiting phase; 0 disables the timeout |
| reconfig_ack | input | 1 | Acknowledge from user logic |
| reconfig_busy | input | 1 | High while user logic reconfigures the transceiver |
| reconfig_req | output | 1 | Reconfiguration request to user logic |
| reconfig_rate | output | 2 | Target rate during an exchange, current rate otherwise |
| pll_div | output | DIV_W | PLL divide ratio for `reconfig_rate` |
| cur_rate | output | 2 | Rate currently in force |
| change_done | output | 1 | One-cycle pulse when a change completes |
| timeout_err | output | 1 | One-cycle pulse when an exchange is abandoned |
| tx_data_valid | output | 1 | Low while a rate exchange is in progress |

## Verification
Assertions check these properties on every cycle: the request drops after an acknowledge, the done and error pulses are mutually exclusive, transmit data is invalid during a request, and the current rate holds between completions. They also check that the timeout counter stays below its limit and that held requests are captured or refused correctly. Only the bench scenarios can show the end-to-end exchange timing under varied acknowledge and busy delays, and the mapping of each rate to its divider. The same applies to serving a held request after completion, the exact length of a timed-out phase, and the acknowledge that arrives on the expiry edge.

// File: rtl/rrh_pkg.sv
// Package: shared codes and types for the rate reconfiguration handshake.
// Assumes two-bit rate codes; code 3 is reserved and never accepted.
package rrh_pkg;

    localparam int RATE_W = 2;

    localparam logic [RATE_W-1:0] CODE_LOW  = 2'd0;
    localparam logic [RATE_W-1:0] CODE_MID  = 2'd1;
    localparam logic [RATE_W-1:0] CODE_HIGH = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ASK  = 3'd1,
        ST_ARM  = 3'd2,
        ST_BUSY = 3'd3,
        ST_DONE = 3'd4
    } hs_state_e;

    // True for the three supported rate codes.
    function automatic logic rate_legal(input logic [RATE_W-1:0] code);
        return code != 2'd3;
    endfunction

endpackage

// File: rtl/rrh_div_map.sv
// Module: maps a rate code onto the transmit PLL divide ratio.
// Assumes every rate derives from the same reference clock, so a rate
// differs from another only in its integer divider.
module rrh_div_map #(
    parameter int DIV_W    = 8,
    parameter int DIV_LOW  = 12,
    parameter int DIV_MID  = 20,
    parameter int DIV_HIGH = 40
) (
    input  logic [rrh_pkg::RATE_W-1:0] code,
    output logic [DIV_W-1:0]           div
);
    import rrh_pkg::*;

    // Purpose: pick the divider for the given code (reserved code keeps low rate).
    always_comb begin
        unique case (code)
            CODE_MID:  div = DIV_W'(DIV_MID);
            CODE_HIGH: div = DIV_W'(DIV_HIGH);
            default:   div = DIV_W'(DIV_LOW);
        endcase
    end

endmodule

// File: rtl/rrh_pending.sv
// Module: one-entry holding slot for incoming rate requests.
// Assumes the controller pulses 'take' only when the slot is valid. A new
// legal request overwrites the held one; a reserved code is refused.
module rrh_pending (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       new_valid,
    input  logic [rrh_pkg::RATE_W-1:0] new_code,
    input  logic                       take,
    output logic                       pend_valid,
    output logic [rrh_pkg::RATE_W-1:0] pend_code
);
    import rrh_pkg::*;

    logic accept;
    assign accept = new_valid && rate_legal(new_code);

    // Purpose: capture legal requests, release the slot when the controller takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_code  <= CODE_LOW;
        end else if (accept) begin
            pend_valid <= 1'b1;
            pend_code  <= new_code;
        end else if (take) begin
            pend_valid <= 1'b0;
        end
    end

    // R8
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (pend_valid && pend_code == $past(new_code)));

    // R9
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (new_valid && !rate_legal(new_code) && !take) |=> $stable(pend_valid) && $stable(pend_code));

endmodule

// File: rtl/rrh_timer.sv
// Module: per-phase watchdog counter for the handshake.
// Assumes 'restart' is high on every phase change and that the limit is
// altered only while no phase is active. A zero limit never expires.
module rrh_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             restart,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

    logic [TMO_W-1:0] cnt_q;

    // Purpose: count cycles spent in the current waiting phase, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !active) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = active && (limit != '0) && (cnt_q >= limit - 1'b1);

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && limit != '0 && $stable(limit)) |-> cnt_q < limit);

endmodule

// File: rtl/rrh_ctrl.sv
// Module: sequencer for the request / acknowledge / busy exchange.
// Assumes user logic raises ack before busy and owns the busy level;
// progress on an edge always wins over an expiring timer.
module rrh_ctrl #(
    parameter logic [rrh_pkg::RATE_W-1:0] DEFAULT_RATE = 2'd0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pend_valid,
    input  logic [rrh_pkg::RATE_W-1:0] pend_code,
    input  logic                       ack,
    input  logic                       busy,
    input  logic                       expire,
    output logic                       take,
    output logic                       waiting,
    output logic                       restart,
    output logic                       in_req,
    output logic                       in_op,
    output logic                       done,
    output logic                       err,
    output logic [rrh_pkg::RATE_W-1:0] target,
    output logic [rrh_pkg::RATE_W-1:0] cur_rate
);
    import rrh_pkg::*;

    hs_state_e state_q, state_d;
    logic      timed_out;

    // Purpose: next-state decision; progress is checked before the timeout.
    always_comb begin
        state_d   = state_q;
        take      = 1'b0;
        timed_out = 1'b0;
        unique case (state_q)
            ST_IDLE: if (pend_valid) begin
                take    = 1'b1;
                state_d = ST_ASK;
            end
            ST_ASK: if (ack) state_d = ST_ARM;
                    else if (expire) begin state_d = ST_IDLE; timed_out = 1'b1; end
            ST_ARM: if (busy) state_d = ST_BUSY;
                    else if (expire) begin state_d = ST_IDLE; timed_out = 1'b1; end
            ST_BUSY: if (!busy) state_d = ST_DONE;
                     else if (expire) begin state_d = ST_IDLE; timed_out = 1'b1; end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: state, target, committed rate and error pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            target   <= DEFAULT_RATE;
            cur_rate <= DEFAULT_RATE;
            err      <= 1'b0;
        end else begin
            state_q <= state_d;
            err     <= timed_out;
            if (take) target <= pend_code;
            if (state_q == ST_DONE) cur_rate <= target;
        end
    end

    assign waiting = (state_q == ST_ASK) || (state_q == ST_ARM) || (state_q == ST_BUSY);
    assign restart = (state_d != state_q);
    assign in_req  = (state_q == ST_ASK);
    assign in_op   = (state_q != ST_IDLE);
    assign done    = (state_q == ST_DONE);

    // R6
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cur_rate == $past(target));

    // R8
    target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_op && !done) |=> $stable(target));

endmodule

// File: rtl/rate_reconfig_hs.sv
// Module: top of the link rate reconfiguration handshake.
// Assumes a synchronous active-low reset held for at least one edge after
// power-up; user logic drives ack and busy synchronously to clk.
module rate_reconfig_hs #(
    parameter int                         DIV_W        = 8,
    parameter int                         TMO_W        = 16,
    parameter int                         DIV_LOW      = 12,
    parameter int                         DIV_MID      = 20,
    parameter int                         DIV_HIGH     = 40,
    parameter logic [rrh_pkg::RATE_W-1:0] DEFAULT_RATE = 2'd0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rate_req_valid,
    input  logic [rrh_pkg::RATE_W-1:0] rate_req_code,
    input  logic [TMO_W-1:0]           timeout_limit,
    input  logic                       reconfig_ack,
    input  logic                       reconfig_busy,
    output logic                       reconfig_req,
    output logic [rrh_pkg::RATE_W-1:0] reconfig_rate,
    output logic [DIV_W-1:0]           pll_div,
    output logic [rrh_pkg::RATE_W-1:0] cur_rate,
    output logic                       change_done,
    output logic                       timeout_err,
    output logic                       tx_data_valid
);
    import rrh_pkg::*;

    logic                pend_valid;
    logic [RATE_W-1:0]   pend_code;
    logic                take;
    logic                waiting;
    logic                restart;
    logic                expire;
    logic                in_req;
    logic                in_op;
    logic [RATE_W-1:0]   target;

    rrh_pending u_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .new_valid  (rate_req_valid),
        .new_code   (rate_req_code),
        .take       (take),
        .pend_valid (pend_valid),
        .pend_code  (pend_code)
    );

    rrh_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (waiting),
        .restart (restart),
        .limit   (timeout_limit),
        .expire  (expire)
    );

    rrh_ctrl #(.DEFAULT_RATE(DEFAULT_RATE)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_valid (pend_valid),
        .pend_code  (pend_code),
        .ack        (reconfig_ack),
        .busy       (reconfig_busy),
        .expire     (expire),
        .take       (take),
        .waiting    (waiting),
        .restart    (restart),
        .in_req     (in_req),
        .in_op      (in_op),
        .done       (change_done),
        .err        (timeout_err),
        .target     (target),
        .cur_rate   (cur_rate)
    );

    assign reconfig_req  = in_req;
    assign tx_data_valid = !in_op;
    assign reconfig_rate = in_op ? target : cur_rate;

    rrh_div_map #(
        .DIV_W    (DIV_W),
        .DIV_LOW  (DIV_LOW),
        .DIV_MID  (DIV_MID),
        .DIV_HIGH (DIV_HIGH)
    ) u_div (
        .code (reconfig_rate),
        .div  (pll_div)
    );

    // R4
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reconfig_req && reconfig_ack) |=> !reconfig_req);

    // R7
    quiet_during_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reconfig_req || change_done) |-> !tx_data_valid);

    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(change_done && timeout_err));

    // R6
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !change_done |=> $stable(cur_rate));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        change_done |=> !change_done);

endmodule

// File: tb/rate_reconfig_hs_bench.sv
// Bench: directed scenarios, one task each; user logic modelled in tasks
// with varied acknowledge and busy delays. Inputs change on falling edges,
// outputs are sampled on falling edges.
module rate_reconfig_hs_bench;

    localparam int CLK_NS = 10;
    localparam int TMO_W  = 16;
    localparam int DIV_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rate_req_valid = 1'b0;
    logic [1:0]        rate_req_code = 2'd0;
    logic [TMO_W-1:0]  timeout_limit = 16'd64;
    logic              reconfig_ack = 1'b0;
    logic              reconfig_busy = 1'b0;
    logic              reconfig_req;
    logic [1:0]        reconfig_rate;
    logic [DIV_W-1:0]  pll_div;
    logic [1:0]        cur_rate;
    logic              change_done;
    logic              timeout_err;
    logic              tx_data_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    rate_reconfig_hs u_rate_reconfig_hs (
        .clk            (clk),
        .rst_n          (rst_n),
        .rate_req_valid (rate_req_valid),
        .rate_req_code  (rate_req_code),
        .timeout_limit  (timeout_limit),
        .reconfig_ack   (reconfig_ack),
        .reconfig_busy  (reconfig_busy),
        .reconfig_req   (reconfig_req),
        .reconfig_rate  (reconfig_rate),
        .pll_div        (pll_div),
        .cur_rate       (cur_rate),
        .change_done    (change_done),
        .timeout_err    (timeout_err),
        .tx_data_valid  (tx_data_valid)
    );

    function automatic int exp_div(input int code);
        case (code)
            1:       return 20;
            2:       return 40;
            default: return 12;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Pulse a request and confirm the request output rises two edges later.
    task automatic send_req(input int code, input bit expect_rise);
        rate_req_valid = 1'b1;
        rate_req_code  = code[1:0];
        step();
        rate_req_valid = 1'b0;
        if (expect_rise) begin
            chk(reconfig_req == 1'b0, "R3 req early", reconfig_req, 0);
            step();
            chk(reconfig_req == 1'b1, "R3 req raised", reconfig_req, 1);
            chk(reconfig_rate == code[1:0], "R3 target code", reconfig_rate, code);
            chk(pll_div == exp_div(code), "R2 divider during request", pll_div, exp_div(code));
            chk(tx_data_valid == 1'b0, "R7 data quiet in request", tx_data_valid, 0);
        end
    endtask

    // Model user logic acknowledge after a delay.
    task automatic ack_phase(input int dly);
        for (int i = 0; i < dly; i++) begin
            chk(reconfig_req == 1'b1, "R4 req held", reconfig_req, 1);
            step();
        end
        reconfig_ack = 1'b1;
        step();
        reconfig_ack = 1'b0;
        chk(reconfig_req == 1'b0, "R4 req dropped after ack", reconfig_req, 0);
    endtask

    // Model the busy phase; ends at the negedge where done should show.
    task automatic busy_phase(input int dly, input int len);
        for (int i = 0; i < dly; i++) step();
        reconfig_busy = 1'b1;
        for (int i = 0; i < len; i++) begin
            step();
            chk(change_done == 1'b0, "R5 no done while busy", change_done, 0);
        end
        reconfig_busy = 1'b0;
        step();
    endtask

    task automatic finish_checks(input int code, input int old);
        chk(change_done == 1'b1, "R5 done pulse", change_done, 1);
        chk(tx_data_valid == 1'b0, "R7 data quiet at done", tx_data_valid, 0);
        chk(cur_rate == old[1:0], "R6 rate held at done", cur_rate, old);
        step();
        chk(change_done == 1'b0, "R5 done one cycle", change_done, 0);
        chk(cur_rate == code[1:0], "R6 rate committed", cur_rate, code);
        chk(tx_data_valid == 1'b1, "R7 data valid again", tx_data_valid, 1);
        chk(pll_div == exp_div(code), "R2 divider after change", pll_div, exp_div(code));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        chk(cur_rate == 2'd0, "R1 default rate", cur_rate, 0);
        chk(reconfig_req == 1'b0, "R1 no request", reconfig_req, 0);
        chk(change_done == 1'b0, "R1 no done", change_done, 0);
        chk(timeout_err == 1'b0, "R1 no error", timeout_err, 0);
        chk(tx_data_valid == 1'b1, "R1 data valid", tx_data_valid, 1);
        chk(pll_div == 12, "R1 default divider", pll_div, 12);
    endtask

    task automatic t_change(input int code, input int ackd, input int busyd, input int blen);
        int old;
        old = cur_rate;
        send_req(code, 1'b1);
        ack_phase(ackd);
        busy_phase(busyd, blen);
        finish_checks(code, old);
    endtask

    task automatic t_all_rates();
        for (int k = 0; k < 9; k++) begin
            t_change(k % 3, $urandom_range(0, 12), $urandom_range(0, 8), $urandom_range(1, 15));
            step();
        end
    endtask

    task automatic t_queue();
        int old;
        old = cur_rate;
        send_req(1, 1'b1);
        ack_phase(2);
        reconfig_busy = 1'b1;
        step();
        send_req(2, 1'b0);
        send_req(3, 1'b0);
        chk(reconfig_rate == 2'd1, "R8 current target unchanged", reconfig_rate, 1);
        reconfig_busy = 1'b0;
        step();
        finish_checks(1, old);
        step();
        chk(reconfig_req == 1'b1, "R8 held request served", reconfig_req, 1);
        chk(reconfig_rate == 2'd2, "R8 held code kept over reserved", reconfig_rate, 2);
        ack_phase(1);
        busy_phase(0, 3);
        finish_checks(2, 1);
        step();
    endtask

    task automatic t_reserved();
        int old;
        old = cur_rate;
        send_req(3, 1'b0);
        step();
        step();
        chk(reconfig_req == 1'b0, "R9 reserved code ignored", reconfig_req, 0);
        chk(cur_rate == old[1:0], "R9 rate unchanged", cur_rate, old);
        chk(tx_data_valid == 1'b1, "R9 data still valid", tx_data_valid, 1);
    endtask

    task automatic t_timeout_ack();
        int old;
        int n;
        old = cur_rate;
        timeout_limit = 16'd5;
        send_req(0, 1'b1);
        n = 0;
        while (reconfig_req && n < 50) begin
            n++;
            step();
        end
        chk(n == 5, "R10 request phase length", n, 5);
        chk(timeout_err == 1'b1, "R10 error pulse", timeout_err, 1);
        chk(cur_rate == old[1:0], "R10 rate unchanged", cur_rate, old);
        chk(tx_data_valid == 1'b1, "R10 back to idle", tx_data_valid, 1);
        step();
        chk(timeout_err == 1'b0, "R10 error one cycle", timeout_err, 0);
        timeout_limit = 16'd64;
    endtask

    task automatic t_timeout_busy();
        int old;
        int n;
        old = cur_rate;
        timeout_limit = 16'd6;
        send_req(1, 1'b1);
        ack_phase(0);
        reconfig_busy = 1'b1;
        n = 0;
        while (!timeout_err && n < 50) begin
            n++;
            step();
        end
        chk(timeout_err == 1'b1, "R10 busy phase abandoned", timeout_err, 1);
        chk(n == 7, "R10 busy phase timing", n, 7);
        chk(reconfig_req == 1'b0, "R10 request low after timeout", reconfig_req, 0);
        reconfig_busy = 1'b0;
        step();
        step();
        chk(change_done == 1'b0, "R10 no late done", change_done, 0);
        chk(cur_rate == old[1:0], "R10 rate kept", cur_rate, old);
        timeout_limit = 16'd64;
    endtask

    task automatic t_no_timeout();
        int old;
        old = cur_rate;
        timeout_limit = '0;
        send_req(2, 1'b1);
        for (int i = 0; i < 40; i++) step();
        chk(reconfig_req == 1'b1, "R11 waits without limit", reconfig_req, 1);
        chk(timeout_err == 1'b0, "R11 no error", timeout_err, 0);
        ack_phase(0);
        busy_phase(30, 2);
        finish_checks(2, old);
        timeout_limit = 16'd64;
        step();
    endtask

    task automatic t_ack_on_expiry();
        int old;
        old = cur_rate;
        timeout_limit = 16'd3;
        send_req(0, 1'b1);
        step();
        step();
        reconfig_ack = 1'b1;
        step();
        reconfig_ack = 1'b0;
        chk(timeout_err == 1'b0, "R12 ack wins over expiry", timeout_err, 0);
        chk(tx_data_valid == 1'b0, "R12 exchange continues", tx_data_valid, 0);
        busy_phase(0, 1);
        finish_checks(0, old);
        timeout_limit = 16'd64;
        step();
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_all_rates();
        t_queue();
        t_reserved();
        t_timeout_ack();
        t_timeout_busy();
        t_no_timeout();
        t_ack_on_expiry();
        t_change(1, 3, 2, 4);
        report();
    end

endmodule